// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits next to a small 32-bit processor core and takes over the core's control flow at two moments: right after reset, and when an external interrupt level wins against the core's current priority mask. While it works it holds the core stalled. It reaches memory through a simple request/ready port and updates the core's program counter, stack pointer and status word through one-cycle write strobes.

At reset it fetches a start address and an initial stack pointer from two fixed low addresses and sets the status word to the highest mask. After that it keeps sampling a 4-bit request level while idle. At each instruction boundary that is not a branch delay slot, it compares the sampled level with the mask in status bits 7:4. A level above the mask starts the entry sequence. The sequence sends a one-cycle acknowledge, saves status and then PC on the stack, reads a handler address from a vector table, and writes the new register values back to the core.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst` is high and afterwards, the block reads the word at address 0 and then the word at address 4. It then asserts `pc_we`, `sp_we` and `sr_we` together for one cycle with those two words and status 0x000000F0. `stall` stays high from reset until that write cycle ends, for exactly M+1 cycles after `rst` falls, where M is the number of cycles with `mem_req` high.
- R2: While idle, the block registers `irq_level` on every clock. The registered value stays frozen from acceptance until the sequence ends. Level 0 never starts a sequence.
- R3: A sequence starts only on a clock where `boundary` is high, `delay_slot` is low and the registered level is strictly greater than `cur_sr[7:4]`. A level equal to the mask is refused, so level 15 is refused at mask 15.
- R4: A refused request stays pending and is evaluated again at the next qualifying boundary.
- R5: In the cycle after acceptance, `ack_valid` is high for exactly one cycle and carries the accepted level on `ack_level`. No memory request is made in that cycle.
- R6: The first access writes `cur_sr` to `cur_sp`-4. The second writes `cur_pc` to `cur_sp`-8.
- R7: The third access reads the word at `cur_vbr` + 4*(64 + level/2), using integer division.
- R8: One cycle raises `pc_we`, `sp_we` and `sr_we` together. It writes the fetched word to PC and `cur_sp`-8 to SP. It writes `cur_sr` to SR with bits 7:4 replaced by the accepted level and all other bits kept.
- R9: `stall` rises in the acknowledge cycle and lasts exactly max(13, M+3) cycles, where M is the number of cycles with `mem_req` high in the sequence.
- R10: A request is accepted in a cycle where `mem_req` and `mem_ready` are both high. Until then `mem_req`, `mem_we` and `mem_addr` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_level | input | 4 | External request level, 0 = none |
| boundary | input | 1 | Core is at an instruction boundary |
| delay_slot | input | 1 | The boundary falls inside a branch delay slot |
| cur_pc | input | 32 | Core program counter |
| cur_sp | input | 32 | Core stack pointer |
| cur_sr | input | 32 | Core status word, mask in bits 7:4 |
| cur_vbr | input | 32 | Vector table base |
| stall | output | 1 | Holds the core while a sequence runs |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 32 | New PC |
| sp_we | output | 1 | SP write strobe |
| sp_wdata | output | 32 | New SP |
| sr_we | output | 1 | Status write strobe |
| sr_wdata | output | 32 | New status word |
| ack_valid | output | 1 | Interrupt accepted, one cycle |
| ack_level | output | 4 | Accepted level |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Completes the pending access |

## Verification
A corrupted pending level or a skipped mask test shows up as an acknowledge in the wrong cycle, or a missing one. The bench catches this at the first clock after the deciding boundary. A wrong sequencer state shows up as a stack or vector access that is out of order or at the wrong address, and the bench flags it on the handshake cycle. A wrong saturating counter shows up as a stall run of the wrong length, detected when `stall` falls. A lost captured context shows up in the single write-back cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int XLEN      = 32;
    localparam int LVL_W     = 4;
    localparam int MASK_LSB  = 4;
    localparam int VEC_BASE  = 64;
    localparam int VEC_SHIFT = 2;
    localparam int MIN_STALL = 13;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam word_t PTR_STEP    = word_t'(4);
    localparam word_t RST_PC_ADDR = word_t'(0);
    localparam word_t RST_SP_ADDR = word_t'(4);
    localparam word_t MASK_FIELD  = word_t'((1 << LVL_W) - 1) << MASK_LSB;
    localparam word_t SR_RESET    = MASK_FIELD;

    typedef enum logic [3:0] {
        S_RST_PC, S_RST_SP, S_IDLE, S_ACK, S_PUSH_SR,
        S_PUSH_PC, S_FETCH, S_PAD, S_COMMIT
    } seq_state_t;

    typedef struct packed {
        word_t sr;
        word_t pc;
        word_t sp;
        word_t vbr;
    } core_ctx_t;

    function automatic lvl_t mask_of(input word_t sr);
        return sr[MASK_LSB +: LVL_W];
    endfunction

    function automatic word_t with_mask(input word_t sr, input lvl_t lvl);
        return (sr & ~MASK_FIELD) | (word_t'(lvl) << MASK_LSB);
    endfunction

    function automatic word_t vec_addr(input word_t vbr, input lvl_t lvl);
        return vbr + ((word_t'(VEC_BASE) + word_t'(lvl >> 1)) << VEC_SHIFT);
    endfunction

endpackage

// File: rtl/irq_seq_gate.sv
module irq_seq_gate
    import irq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic boundary,
    input  logic delay_slot,
    input  lvl_t irq_level,
    input  lvl_t cur_mask,
    output lvl_t pend,
    output logic accept
);

    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else if (!busy)
            pend <= irq_level;
    end

    assign accept = !busy && boundary && !delay_slot && (pend > cur_mask);

    AST_PEND_FROZEN: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> $stable(pend)); // R2

endmodule

// File: rtl/irq_seq_timer.sv
module irq_seq_timer #(
    parameter int MIN_STALL = 13,
    localparam int CW = $clog2(MIN_STALL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic [CW-1:0] cnt,
    output logic          min_met
);

    localparam logic [CW-1:0] LAST    = CW'(MIN_STALL - 1);
    localparam logic [CW-1:0] PAD_END = CW'(MIN_STALL - 2);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= LAST;
        else if (start)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign min_met = (cnt >= PAD_END);

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
    import irq_seq_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  lvl_t          pend,
    input  core_ctx_t     ctx,
    input  logic          min_met,
    input  logic [CW-1:0] cnt,
    input  word_t         mem_rdata,
    input  logic          mem_ready,
    output logic          stall,
    output logic          ack_valid,
    output lvl_t          ack_level,
    output logic          mem_req,
    output logic          mem_we,
    output word_t         mem_addr,
    output word_t         mem_wdata,
    output logic          commit,
    output word_t         pc_wdata,
    output word_t         sp_wdata,
    output word_t         sr_wdata
);

    seq_state_t state;
    logic       rst_seq;
    core_ctx_t  ctx_q;
    lvl_t       lvl_q;
    word_t      npc_q;
    word_t      nsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_RST_PC;
            rst_seq <= 1'b1;
            ctx_q   <= '0;
            lvl_q   <= '0;
            npc_q   <= '0;
            nsp_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (accept) begin
                    state   <= S_ACK;
                    rst_seq <= 1'b0;
                    ctx_q   <= ctx;
                    lvl_q   <= pend;
                end
                S_ACK:     state <= S_PUSH_SR;
                S_PUSH_SR: if (mem_ready) state <= S_PUSH_PC;
                S_PUSH_PC: if (mem_ready) begin
                    nsp_q <= ctx_q.sp - (PTR_STEP << 1);
                    state <= S_FETCH;
                end
                S_FETCH: if (mem_ready) begin
                    npc_q <= mem_rdata;
                    state <= S_PAD;
                end
                S_PAD:    if (min_met) state <= S_COMMIT;
                S_RST_PC: if (mem_ready) begin
                    npc_q <= mem_rdata;
                    state <= S_RST_SP;
                end
                S_RST_SP: if (mem_ready) begin
                    nsp_q <= mem_rdata;
                    state <= S_COMMIT;
                end
                S_COMMIT: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx_q.sp - PTR_STEP;
                mem_wdata = ctx_q.sr;
            end
            S_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx_q.sp - (PTR_STEP << 1);
                mem_wdata = ctx_q.pc;
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr(ctx_q.vbr, lvl_q);
            end
            S_RST_PC: begin
                mem_req  = 1'b1;
                mem_addr = RST_PC_ADDR;
            end
            S_RST_SP: begin
                mem_req  = 1'b1;
                mem_addr = RST_SP_ADDR;
            end
            default: ;
        endcase
    end

    assign stall     = (state != S_IDLE);
    assign ack_valid = (state == S_ACK);
    assign ack_level = lvl_q;
    assign commit    = (state == S_COMMIT);
    assign pc_wdata  = npc_q;
    assign sp_wdata  = nsp_q;
    assign sr_wdata  = rst_seq ? SR_RESET : with_mask(ctx_q.sr, lvl_q);

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> !ack_valid); // R5
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
    AST_PC_PUSH_SLOT: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_wdata == ctx.pc && state == S_PUSH_PC)
            |-> mem_addr == ctx.sp - (PTR_STEP << 1)); // R6
    AST_MASK_RAISED: assert property (@(posedge clk) disable iff (rst)
        (commit && !rst_seq) |-> (mask_of(sr_wdata) > mask_of(ctx.sr)
            && (sr_wdata & ~MASK_FIELD) == (ctx.sr & ~MASK_FIELD))); // R8
    AST_STALL_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (commit && !rst_seq) |-> cnt == CW'(MIN_STALL - 1)); // R9

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  irq_level,
    input  logic        boundary,
    input  logic        delay_slot,
    input  logic [31:0] cur_pc,
    input  logic [31:0] cur_sp,
    input  logic [31:0] cur_sr,
    input  logic [31:0] cur_vbr,
    output logic        stall,
    output logic        pc_we,
    output logic [31:0] pc_wdata,
    output logic        sp_we,
    output logic [31:0] sp_wdata,
    output logic        sr_we,
    output logic [31:0] sr_wdata,
    output logic        ack_valid,
    output logic [3:0]  ack_level,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready
);

    localparam int CW = $clog2(MIN_STALL);

    lvl_t          pend;
    logic          accept;
    logic [CW-1:0] cnt;
    logic          min_met;
    logic          commit;
    core_ctx_t     ctx;

    assign ctx = '{sr: cur_sr, pc: cur_pc, sp: cur_sp, vbr: cur_vbr};

    irq_seq_gate i_gate (
        .clk        (clk),
        .rst        (rst),
        .busy       (stall),
        .boundary   (boundary),
        .delay_slot (delay_slot),
        .irq_level  (irq_level),
        .cur_mask   (mask_of(cur_sr)),
        .pend       (pend),
        .accept     (accept)
    );

    irq_seq_timer #(.MIN_STALL(MIN_STALL)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .cnt     (cnt),
        .min_met (min_met)
    );

    irq_seq_ctrl #(.CW(CW)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .pend      (pend),
        .ctx       (ctx),
        .min_met   (min_met),
        .cnt       (cnt),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .stall     (stall),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .commit    (commit),
        .pc_wdata  (pc_wdata),
        .sp_wdata  (sp_wdata),
        .sr_wdata  (sr_wdata)
    );

    assign pc_we = commit;
    assign sp_we = commit;
    assign sr_we = commit;

    AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(boundary && !delay_slot)); // R3

endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, boundary, delay_slot;
    logic [3:0]  irq_level;
    logic [31:0] m_pc, m_sp, m_sr;
    localparam logic [31:0] VBR = 32'h100;
    logic        stall, pc_we, sp_we, sr_we, ack_valid, mem_req, mem_we, mem_ready;
    logic [31:0] pc_wdata, sp_wdata, sr_wdata, mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  ack_level;

    logic [31:0] mem [0:255];
    int wait_n, wait_cnt;
    assign mem_rdata = mem[mem_addr[9:2]];
    assign mem_ready = mem_req && (wait_cnt >= wait_n);

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst(rst), .irq_level(irq_level), .boundary(boundary),
        .delay_slot(delay_slot), .cur_pc(m_pc), .cur_sp(m_sp), .cur_sr(m_sr),
        .cur_vbr(VBR), .stall(stall), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .sr_we(sr_we), .sr_wdata(sr_wdata),
        .ack_valid(ack_valid), .ack_level(ack_level), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int n_tests = 0, n_fail = 0, n_ack = 0;
    bit          q_we[$];
    logic [31:0] q_addr[$], q_wd[$], c_pc[$], c_sp[$], c_sr[$];
    logic [3:0]  q_ack[$];
    logic [3:0]  ref_pend;
    logic        ref_busy, ack_due, force_en;
    logic [31:0] force_val, va;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural reference: core register file, memory and expected events
    always @(posedge clk) begin
        if (rst) begin
            ref_pend <= '0; ref_busy <= 1'b1; ack_due <= 1'b0; wait_cnt <= 0;
        end else begin
            ack_due <= 1'b0;
            if (mem_req && mem_ready) begin
                wait_cnt <= 0;
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            end else if (mem_req) wait_cnt <= wait_cnt + 1;
            if (pc_we) begin
                m_pc <= pc_wdata; m_sp <= sp_wdata; m_sr <= sr_wdata; ref_busy <= 1'b0;
            end else if (force_en) m_sr <= force_val;
            if (!ref_busy) begin
                if (boundary && !delay_slot && ref_pend > m_sr[7:4]) begin
                    va = VBR + 32'd4 * (32'd64 + 32'(ref_pend / 2));
                    q_we.push_back(1'b1); q_addr.push_back(m_sp - 4); q_wd.push_back(m_sr);
                    q_we.push_back(1'b1); q_addr.push_back(m_sp - 8); q_wd.push_back(m_pc);
                    q_we.push_back(1'b0); q_addr.push_back(va);       q_wd.push_back(32'h0);
                    c_pc.push_back(mem[va[9:2]]);
                    c_sp.push_back(m_sp - 8);
                    c_sr.push_back((m_sr & ~32'hF0) | (32'(ref_pend) << 4));
                    q_ack.push_back(ref_pend);
                    ack_due  <= 1'b1;
                    ref_busy <= 1'b1;
                end
                ref_pend <= irq_level;
            end
        end
    end

    int run_len, run_mem, exp_len;
    bit run_rst, prev_wait, prev_we;
    logic [31:0] prev_addr;

    always @(negedge clk) begin
        if (rst) begin
            run_rst = 1'b1; run_len = 0; run_mem = 0; prev_wait = 1'b0;
        end else begin
            chk(stall === ref_busy, "R9 stall level", 32'(stall), 32'(ref_busy));
            if (ack_due || ack_valid) begin
                if (ack_valid) n_ack++;
                chk(ack_due && ack_valid === 1'b1 && q_ack.size() > 0 && ack_level === q_ack[0],
                    "R5 acknowledge", {27'd0, ack_valid, ack_level},
                    {27'd0, ack_due, (q_ack.size() > 0 ? q_ack[0] : 4'hx)});
                chk(mem_req === 1'b0, "R5 no access in ack cycle", 32'(mem_req), 32'd0);
                if (q_ack.size() > 0) void'(q_ack.pop_front());
            end
            if (prev_wait)
                chk(mem_req === 1'b1 && mem_addr === prev_addr && mem_we === prev_we,
                    "R10 request held", mem_addr, prev_addr);
            prev_wait = mem_req && !mem_ready;
            prev_addr = mem_addr;
            prev_we   = mem_we;
            if (mem_req && mem_ready) begin
                if (q_addr.size() == 0)
                    chk(1'b0, "R1 R6 R7 unexpected access", mem_addr, 32'hx);
                else begin
                    chk(mem_we === q_we[0] && mem_addr === q_addr[0] && (!mem_we || mem_wdata === q_wd[0]),
                        "R1 R6 R7 access", mem_we ? mem_wdata : mem_addr, q_we[0] ? q_wd[0] : q_addr[0]);
                    chk(mem_we === q_we[0], "R6 R7 direction", 32'(mem_we), 32'(q_we[0]));
                    void'(q_we.pop_front()); void'(q_addr.pop_front()); void'(q_wd.pop_front());
                end
            end
            if (pc_we || sp_we || sr_we) begin
                if (c_pc.size() == 0)
                    chk(1'b0, "R8 unexpected write-back", pc_wdata, 32'hx);
                else begin
                    chk(pc_we && sp_we && sr_we, "R8 strobes together", {29'd0, pc_we, sp_we, sr_we}, 32'd7);
                    chk(pc_wdata === c_pc[0], "R8 R1 new pc", pc_wdata, c_pc[0]);
                    chk(sp_wdata === c_sp[0], "R8 R1 new sp", sp_wdata, c_sp[0]);
                    chk(sr_wdata === c_sr[0], "R8 R1 new sr", sr_wdata, c_sr[0]);
                    void'(c_pc.pop_front()); void'(c_sp.pop_front()); void'(c_sr.pop_front());
                end
            end
            if (stall) begin
                run_len++;
                if (mem_req) run_mem++;
            end else if (run_len > 0) begin
                exp_len = run_rst ? run_mem + 1 : ((run_mem + 3 > 13) ? run_mem + 3 : 13);
                chk(run_len == exp_len, run_rst ? "R1 reset stall length" : "R9 stall length",
                    32'(run_len), 32'(exp_len));
                run_len = 0; run_mem = 0; run_rst = 1'b0;
            end
        end
    end

    task automatic pulse(input bit ds);
        boundary = 1'b1; delay_slot = ds;
        @(negedge clk);
        boundary = 1'b0; delay_slot = 1'b0;
    endtask

    task automatic set_sr(input logic [31:0] v);
        force_val = v; force_en = 1'b1;
        @(negedge clk);
        force_en = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (stall && g < 200) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; irq_level = '0; boundary = 1'b0; delay_slot = 1'b0;
        wait_n = 0; force_en = 1'b0; force_val = '0;
        for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | 32'(i);
        mem[0] = 32'h0000_1000;
        mem[1] = 32'h0000_03F0;
        // R1 reset fetch expectations
        q_we.push_back(1'b0); q_addr.push_back(32'h0); q_wd.push_back(32'h0);
        q_we.push_back(1'b0); q_addr.push_back(32'h4); q_wd.push_back(32'h0);
        c_pc.push_back(32'h1000); c_sp.push_back(32'h3F0); c_sr.push_back(32'hF0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        wait_idle();
        chk(m_pc === 32'h1000, "R1 pc after reset", m_pc, 32'h1000);
        chk(m_sp === 32'h3F0,  "R1 sp after reset", m_sp, 32'h3F0);
        chk(m_sr === 32'hF0,   "R1 sr after reset", m_sr, 32'hF0);

        // R3: level 15 refused at mask 15
        irq_level = 4'd15;
        @(negedge clk);
        pulse(1'b0);
        repeat (3) @(negedge clk);
        chk(n_ack == 0 && !stall, "R3 level 15 at mask 15", 32'(n_ack), 32'd0);

        // R4: delay slot refuses, request stays pending
        set_sr(32'h0000_0303);
        irq_level = 4'd5;
        @(negedge clk);
        pulse(1'b1);
        repeat (2) @(negedge clk);
        chk(n_ack == 0, "R4 refused in delay slot", 32'(n_ack), 32'd0);
        pulse(1'b0);
        wait_idle();
        chk(n_ack == 1, "R4 pending accepted later", 32'(n_ack), 32'd1);
        chk(m_sr === 32'h353, "R8 mask replaced", m_sr, 32'h353);
        chk(m_sp === 32'h3E8, "R8 stack lowered", m_sp, 32'h3E8);
        chk(mem[32'h3EC >> 2] === 32'h303,  "R6 status saved first", mem[32'h3EC >> 2], 32'h303);
        chk(mem[32'h3E8 >> 2] === 32'h1000, "R6 pc saved second", mem[32'h3E8 >> 2], 32'h1000);
        chk(m_pc === 32'hA500_0082, "R7 vector 66", m_pc, 32'hA500_0082);

        // R3: equal level refused, higher accepted
        pulse(1'b0);
        repeat (3) @(negedge clk);
        chk(n_ack == 1, "R3 equal level refused", 32'(n_ack), 32'd1);
        irq_level = 4'd6;
        @(negedge clk);
        pulse(1'b0);
        wait_idle();
        chk(n_ack == 2, "R3 higher level accepted", 32'(n_ack), 32'd2);
        chk(m_pc === 32'hA500_0083, "R7 vector 67", m_pc, 32'hA500_0083);
        chk(m_sr === 32'h363, "R8 mask 6", m_sr, 32'h363);

        // R2: level 0 never starts a sequence
        set_sr(32'h0);
        irq_level = 4'd0;
        repeat (2) @(negedge clk);
        pulse(1'b0);
        repeat (3) @(negedge clk);
        chk(n_ack == 2, "R2 level 0 ignored", 32'(n_ack), 32'd2);

        // R9 R10: wait states stretch the stall
        wait_n = 3;
        irq_level = 4'd9;
        repeat (2) @(negedge clk);
        pulse(1'b0);
        wait_idle();
        wait_n = 0;
        chk(n_ack == 3, "R10 slow memory sequence", 32'(n_ack), 32'd3);
        chk(m_pc === 32'hA500_0084, "R7 vector 68", m_pc, 32'hA500_0084);

        // R2: level changes during a sequence are not sampled
        set_sr(32'h0);
        irq_level = 4'd3;
        repeat (2) @(negedge clk);
        pulse(1'b0);
        irq_level = 4'd12;
        wait_idle();
        irq_level = 4'd0;
        pulse(1'b0);
        repeat (3) @(negedge clk);
        chk(n_ack == 4, "R2 level frozen while busy", 32'(n_ack), 32'd4);
        chk(m_sr[7:4] === 4'd3, "R8 mask 3", 32'(m_sr[7:4]), 32'd3);

        repeat (4) @(negedge clk);
        chk(q_addr.size() == 0 && c_pc.size() == 0 && q_ack.size() == 0,
            "R5 R6 R7 R8 all expected events seen", 32'(q_addr.size() + c_pc.size() + q_ack.size()), 32'd0);
        summary();
        $finish;
    end

endmodule